// File: doc/BRIEF.md
# Control-Read Data Stage Sequencer

This block runs the device side of the data stage of a USB control read. When a setup packet arrives it takes the length the host asked for, the number of bytes the device has ready, and the endpoint-0 maximum packet size. From these it works out how many bytes will actually go out and whether the stage must end with a zero-length packet. It then answers each IN token with the payload length of the next data packet. Once the stage is complete, it answers IN tokens with STALL instead.

The remaining byte count moves forward only when the host acknowledges a packet. A repeated IN without an acknowledge therefore gets the same length again. The block tells the surrounding logic when the data stage is over and the status stage has begun. A stage ends in one of three ways: the requested length has been sent exactly, a short or zero-length packet has been acknowledged, or the host sends an OUT token. A new setup packet always aborts the current stage and reloads the sequencer.

Top module: `ctl_read_seq`

## Requirements
- R1: After reset the sequencer is in neither the data stage nor the status stage, and an IN token is answered with STALL and no data.
- R2: The bytes sent are the smaller of the requested and available lengths. Each packet carries the smaller of the remaining bytes and the maximum packet size. The maximum packet size is 8 shifted left by the 2-bit size select (8, 16, 32 or 64) and is captured on setup.
- R3: The remaining count drops by the packet length only when an acknowledge follows an IN token that was answered with data. An IN without acknowledge, or an acknowledge with no packet outstanding, leaves the next packet length unchanged.
- R4: When the bytes sent equal the requested length, the stage ends after the acknowledge of the last packet with no zero-length packet. This holds even when the length is a multiple of the packet size: a 128-byte request at 64-byte packets gives two packets and then the status stage.
- R5: An acknowledged packet shorter than the maximum packet size ends the data stage.
- R6: When fewer bytes than requested are sent and that count is a multiple of the packet size (zero included), one extra packet of length 0 is offered before the stage ends.
- R7: Any IN token after the data stage is complete is answered with STALL and no data.
- R8: An OUT token during the data stage moves the sequencer to the status stage.
- R9: A setup pulse in any state aborts the current stage and starts a new one from the new lengths.
- R10: A setup with a requested length of 0 goes straight to the status stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_i | input | 1 | Setup packet received; load lengths |
| req_len_i | input | LEN_W | Requested length from the setup packet |
| avail_len_i | input | LEN_W | Bytes the device has ready |
| mps_sel_i | input | SEL_W | Packet size select, size = 8 << select |
| in_tok_i | input | 1 | IN token on endpoint 0 |
| ack_i | input | 1 | Host acknowledged the last data packet |
| out_tok_i | input | 1 | OUT token on endpoint 0 |
| resp_data_o | output | 1 | Answer the current IN with a data packet |
| resp_stall_o | output | 1 | Answer the current IN with STALL |
| pkt_len_o | output | MAX_LOG+1 | Payload length of the next data packet |
| data_stage_o | output | 1 | Data stage in progress |
| status_stage_o | output | 1 | Data stage finished, status stage active |

## Verification
The bench uses the default parameters: 16-bit lengths, a 2-bit size select and a base size of 8. All four packet sizes from 8 to 64 bytes are reachable, as are lengths well beyond several packets. The vector table covers these cases:
- exact-multiple requests with no zero-length packet;
- short device data ending in a tail packet;
- short device data ending in a zero-length packet, including an empty buffer;
- zero-length requests.

Directed cases cover IN retries, stray acknowledges, an OUT abort and a setup arriving mid-stage.

// File: rtl/ctlrd_pkg.sv
package ctlrd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_STATUS = 2'd2
    } ctlrd_st_e;
endpackage

// File: rtl/ctlrd_plan.sv
// Works out the byte total for a new stage and whether it ends with a zero-length packet.
module ctlrd_plan #(
    parameter int LEN_W    = 16,
    parameter int SEL_W    = 2,
    parameter int BASE_LOG = 3
) (
    input  logic [LEN_W-1:0] req_len,
    input  logic [LEN_W-1:0] avail_len,
    input  logic [SEL_W-1:0] sel,
    output logic [LEN_W-1:0] total,
    output logic             zlp_need
);
    logic [LEN_W-1:0] low_mask;

    always_comb begin
        total = (req_len < avail_len) ? req_len : avail_len;
        for (int i = 0; i < LEN_W; i++) begin
            low_mask[i] = (i < (BASE_LOG + int'(sel)));
        end
        zlp_need = (total < req_len) && ((total & low_mask) == '0);
    end
endmodule

// File: rtl/ctlrd_pktlen.sv
// Length of the next packet and whether it is shorter than the packet size.
module ctlrd_pktlen #(
    parameter int LEN_W    = 16,
    parameter int SEL_W    = 2,
    parameter int BASE_LOG = 3,
    localparam int MAX_LOG = BASE_LOG + (1 << SEL_W) - 1,
    localparam int PL_W    = MAX_LOG + 1
) (
    input  logic [LEN_W-1:0] rem,
    input  logic [SEL_W-1:0] sel,
    output logic [PL_W-1:0]  len,
    output logic             is_short
);
    logic [LEN_W-1:0] mps_ext;

    always_comb begin
        mps_ext  = LEN_W'(1) << (BASE_LOG + int'(sel));
        is_short = rem < mps_ext;
        len      = is_short ? rem[PL_W-1:0] : mps_ext[PL_W-1:0];
    end
endmodule

// File: rtl/ctl_read_seq.sv
module ctl_read_seq #(
    parameter int LEN_W    = 16,
    parameter int SEL_W    = 2,
    parameter int BASE_LOG = 3,
    localparam int MAX_LOG = BASE_LOG + (1 << SEL_W) - 1,
    localparam int PL_W    = MAX_LOG + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_i,
    input  logic [LEN_W-1:0] req_len_i,
    input  logic [LEN_W-1:0] avail_len_i,
    input  logic [SEL_W-1:0] mps_sel_i,
    input  logic             in_tok_i,
    input  logic             ack_i,
    input  logic             out_tok_i,
    output logic             resp_data_o,
    output logic             resp_stall_o,
    output logic [PL_W-1:0]  pkt_len_o,
    output logic             data_stage_o,
    output logic             status_stage_o
);
    import ctlrd_pkg::*;

    typedef struct packed {
        ctlrd_st_e        st;
        logic [LEN_W-1:0] rem;
        logic             zlp;
        logic             pend;
        logic [SEL_W-1:0] sel;
    } seq_t;

    seq_t q, d;

    logic [LEN_W-1:0] plan_total;
    logic             plan_zlp;
    logic [PL_W-1:0]  cur_len;
    logic             cur_short;
    logic [LEN_W-1:0] cur_len_ext;

    ctlrd_plan #(.LEN_W(LEN_W), .SEL_W(SEL_W), .BASE_LOG(BASE_LOG)) u_plan (
        .req_len  (req_len_i),
        .avail_len(avail_len_i),
        .sel      (mps_sel_i),
        .total    (plan_total),
        .zlp_need (plan_zlp)
    );

    ctlrd_pktlen #(.LEN_W(LEN_W), .SEL_W(SEL_W), .BASE_LOG(BASE_LOG)) u_len (
        .rem     (q.rem),
        .sel     (q.sel),
        .len     (cur_len),
        .is_short(cur_short)
    );

    assign cur_len_ext = {{(LEN_W-PL_W){1'b0}}, cur_len};

    always_comb begin
        d = q;
        if (setup_i) begin
            d.sel  = mps_sel_i;
            d.rem  = plan_total;
            d.zlp  = plan_zlp;
            d.pend = 1'b0;
            d.st   = (plan_total == '0 && !plan_zlp) ? ST_STATUS : ST_DATA;
        end else if (q.st == ST_DATA) begin
            if (out_tok_i) begin
                d.st   = ST_STATUS;
                d.pend = 1'b0;
            end else if (ack_i && q.pend) begin
                d.rem  = q.rem - cur_len_ext;
                d.pend = 1'b0;
                if (cur_short || (q.rem == cur_len_ext && !q.zlp)) begin
                    d.st = ST_STATUS;
                end
            end else if (in_tok_i) begin
                d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, rem: '0, zlp: 1'b0, pend: 1'b0, sel: '0};
        end else begin
            q <= d;
        end
    end

    assign resp_data_o    = in_tok_i && (q.st == ST_DATA);
    assign resp_stall_o   = in_tok_i && (q.st != ST_DATA);
    assign pkt_len_o      = cur_len;
    assign data_stage_o   = (q.st == ST_DATA);
    assign status_stage_o = (q.st == ST_STATUS);

    assert_len_within_mps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        data_stage_o |-> (int'(pkt_len_o) <= (1 << (BASE_LOG + int'(q.sel)))));

    assert_rem_hold_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!setup_i && !(ack_i && q.pend)) |=> $stable(q.rem));

    assert_rem_no_grow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA && !setup_i) |=> (q.rem <= $past(q.rem)));

    assert_zlp_only_when_owed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stage_o && pkt_len_o == '0) |-> q.zlp);

    assert_stall_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_stage_o && in_tok_i) |-> (resp_stall_o && !resp_data_o));

    assert_stay_in_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA && !setup_i && !out_tok_i && !ack_i) |=> data_stage_o);
endmodule

// File: tb/tb_ctl_read_seq.sv
module tb_ctl_read_seq;
    localparam int LEN_W = 16;
    localparam int SEL_W = 2;
    localparam int PL_W  = 7;
    localparam int NV    = 8;

    localparam int V_REQ  [NV] = '{128, 128, 100, 100,  40, 10,  0, 70};
    localparam int V_AVL  [NV] = '{200, 128,  50,  64, 300,  0, 50, 70};
    localparam int V_SEL  [NV] = '{  3,   3,   2,   2,   0,  1,  3,  3};
    localparam int V_NPKT [NV] = '{  2,   2,   2,   3,   5,  1,  0,  2};
    localparam int V_LAST [NV] = '{ 64,  64,  18,   0,   8,  0,  0,  6};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             setup_i = 1'b0;
    logic [LEN_W-1:0] req_len_i = '0;
    logic [LEN_W-1:0] avail_len_i = '0;
    logic [SEL_W-1:0] mps_sel_i = '0;
    logic             in_tok_i = 1'b0;
    logic             ack_i = 1'b0;
    logic             out_tok_i = 1'b0;
    logic             resp_data_o, resp_stall_o, data_stage_o, status_stage_o;
    logic [PL_W-1:0]  pkt_len_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int g_data, g_stall, g_len;

    always #2 clk = ~clk;

    ctl_read_seq dut (
        .clk(clk), .rst_n(rst_n), .setup_i(setup_i), .req_len_i(req_len_i),
        .avail_len_i(avail_len_i), .mps_sel_i(mps_sel_i), .in_tok_i(in_tok_i),
        .ack_i(ack_i), .out_tok_i(out_tok_i), .resp_data_o(resp_data_o),
        .resp_stall_o(resp_stall_o), .pkt_len_o(pkt_len_o),
        .data_stage_o(data_stage_o), .status_stage_o(status_stage_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_setup(input int req, input int avl, input int sel);
        setup_i = 1'b1; req_len_i = LEN_W'(req); avail_len_i = LEN_W'(avl);
        mps_sel_i = SEL_W'(sel);
        @(posedge clk); @(negedge clk);
        setup_i = 1'b0;
    endtask

    task automatic do_in();
        in_tok_i = 1'b1;
        #1;
        g_data = int'(resp_data_o); g_stall = int'(resp_stall_o); g_len = int'(pkt_len_o);
        @(posedge clk); @(negedge clk);
        in_tok_i = 1'b0;
    endtask

    task automatic do_ack();
        ack_i = 1'b1;
        @(posedge clk); @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic do_out();
        out_tok_i = 1'b1;
        @(posedge clk); @(negedge clk);
        out_tok_i = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 data_stage", int'(data_stage_o), 0);
        chk("R1 status_stage", int'(status_stage_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_in();
        chk("R1 stall", g_stall, 1);
        chk("R1 no data", g_data, 0);

        // Vector table: R2 R4 R5 R6 R10 and R7 after each stage
        for (int v = 0; v < NV; v++) begin
            int mps;
            mps = 8 << V_SEL[v];
            do_setup(V_REQ[v], V_AVL[v], V_SEL[v]);
            for (int k = 0; k < V_NPKT[v]; k++) begin
                do_in();
                chk($sformatf("R2 v%0d p%0d data", v, k), g_data, 1);
                chk($sformatf("R2 v%0d p%0d len", v, k), g_len,
                    (k == V_NPKT[v] - 1) ? V_LAST[v] : mps);
                do_ack();
            end
            chk($sformatf("R4 v%0d status", v), int'(status_stage_o), 1);
            do_in();
            chk($sformatf("R7 v%0d stall", v), g_stall, 1);
            chk($sformatf("R7 v%0d no data", v), g_data, 0);
        end

        // R3: IN retry without ack gives same length; stray ack ignored
        do_setup(100, 100, 2);
        do_in();
        chk("R3 first len", g_len, 32);
        do_in();
        chk("R3 retry len", g_len, 32);
        do_ack();
        do_ack();
        do_in();
        chk("R3 after stray ack len", g_len, 32);
        chk("R3 still data", g_data, 1);

        // R8: OUT ends the data stage
        do_out();
        chk("R8 status", int'(status_stage_o), 1);
        do_in();
        chk("R8 stall after out", g_stall, 1);

        // R9: setup mid-stage reloads
        do_setup(64, 64, 1);
        do_in();
        do_ack();
        do_setup(20, 20, 3);
        chk("R9 data stage", int'(data_stage_o), 1);
        do_in();
        chk("R9 reload len", g_len, 20);
        do_ack();
        chk("R9 short ends", int'(status_stage_o), 1);

        // R10: zero request goes straight to status
        do_setup(0, 0, 0);
        chk("R10 status", int'(status_stage_o), 1);
        chk("R10 no data stage", int'(data_stage_o), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule